// File: doc/BRIEF.md
# Transmit/Receive FIFO Burst Interrupt Logic

This block sits between the host side and the serializer of a 16550-style serial port. It holds one byte FIFO per direction, 64 bytes deep each. It turns the fill levels of those FIFOs into four conditions that the interrupt logic can use:

- transmit-ready, raised when the transmit FIFO has room for a full write burst;
- transmitter-idle, which can stand in for transmit-ready;
- receive-burst, raised when a full read burst is waiting in the receive FIFO;
- receive-timeout, raised when a partial read burst has had no traffic for a while.

Software writes three small configuration bytes through one port, selected by `cfg_sel`:

- a word-count byte that sets the coarse burst sizes, in units of four bytes;
- a command byte that enables the FIFOs, clears them and supplies 0–3 leftover bytes per direction;
- a mode byte that turns on byte granularity for each direction and selects the idle-based transmit condition.

The host pushes transmit bytes and pops receive bytes. The serializer pops transmit bytes and pushes receive bytes. The serializer also reports whether its shifter is busy and gives a tick once per character time. Both FIFO levels are visible at all times.

Top module: `uart_fifo_irq`

## Requirements
- R1: After reset the following hold. Both levels are 0. The FIFOs are disabled. `tx_overflow`, `rx_burst_irq` and `rx_timeout_irq` are 0. `tx_ready_irq` equals `tx_irq_en`.
- R2: A command write (`cfg_sel`=1) sets the FIFO enable from bit 0. Bit 1 clears the receive FIFO and bit 2 clears the transmit FIFO, and the cleared levels read 0 in the cycle after the write. Writing 0x07 clears both FIFOs and enables them.
- R3: The write burst is formed from two parts. The first is 4 × the transmit word count, taken from bits [3:0] of a word-count write (`cfg_sel`=0). The second is the leftover count in command bits [5:4], which is added only when mode bit 1 is set (mode write, `cfg_sel`=2). A result of 0 counts as 1.
- R4: When idle selection is off, `tx_ready_irq` is 1 exactly while `tx_irq_en` is 1 and `tx_level` ≤ capacity − write burst. It drops when a push leaves less free space than one burst, and it rises again when a pop restores the space.
- R5: With mode bit 0 set, `tx_ready_irq` is `tx_irq_en` AND (`tx_level` = 0 AND `ser_busy` = 0). The output `tx_idle` always shows that second term.
- R6: With the FIFOs disabled, each direction has a capacity of 1 byte and both bursts are 1 byte.
- R7: The read burst is formed from two parts. The first is 4 × the receive word count from bits [7:4] of the word-count write. The second is the leftover count in command bits [7:6], added only when mode bit 2 is set. A result of 0 counts as 1. `rx_burst_irq` is `rx_irq_en` AND (`rx_level` ≥ read burst).
- R8: `rx_timeout_irq` rises when both of the following are true. First, 0 < `rx_level` < read burst. Second, 4 `char_tick` pulses have arrived since the last serializer push or host pop. Any such push or pop restarts the count.
- R9: A host push into a full transmit FIFO is dropped and sets `tx_overflow`. That flag stays set until reset or a command write with bit 2 set.
- R10: A host pop from an empty receive FIFO changes nothing, and `rx_data` reads 0x00 while the FIFO is empty.
- R11: Each FIFO delivers bytes in the order they were pushed, and its level counts the bytes it holds.
- R12: A change of burst size applies to the interrupt conditions from the cycle after the write, including while data is in the FIFOs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | 0 word counts, 1 command, 2 mode |
| cfg_data | input | 8 | Configuration write data |
| tx_irq_en | input | 1 | Transmit condition enable |
| rx_irq_en | input | 1 | Receive conditions enable |
| tx_push | input | 1 | Host writes a transmit byte |
| tx_data | input | 8 | Host transmit byte |
| rx_pop | input | 1 | Host reads a receive byte |
| rx_data | output | 8 | Head of receive FIFO, 0 when empty |
| ser_tx_pop | input | 1 | Serializer takes a transmit byte |
| ser_tx_data | output | 8 | Head of transmit FIFO, 0 when empty |
| ser_rx_push | input | 1 | Serializer delivers a receive byte |
| ser_rx_data | input | 8 | Received byte |
| ser_busy | input | 1 | Transmit shifter busy |
| char_tick | input | 1 | One pulse per character time |
| tx_ready_irq | output | 1 | Transmit-ready (or idle) condition |
| rx_burst_irq | output | 1 | Receive burst available |
| rx_timeout_irq | output | 1 | Receive timeout |
| tx_idle | output | 1 | Transmit FIFO empty and shifter idle |
| tx_level | output | 7 | Transmit FIFO byte count |
| rx_level | output | 7 | Receive FIFO byte count |
| tx_overflow | output | 1 | Sticky transmit overflow |

## Verification
Each push, pop, tick or configuration write changes registered state at one clock edge. Every result that follows from it (levels, FIFO heads, all three interrupt conditions, the overflow flag) is due one cycle later, because the outputs are combinational functions of that state. `ser_busy` and `tx_irq_en` are the exception: they reach `tx_ready_irq` and `tx_idle` in the same cycle. Every stimulus is therefore applied just after a rising edge, and every result is sampled 1 ns after the next rising edge. The burst size is measured at the ports: the bench counts how many pushes it takes until `tx_ready_irq` falls or `rx_burst_irq` rises.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

    localparam int WORD_CNT_W     = 4;
    localparam int EXTRA_W        = 2;
    localparam int BYTES_PER_WORD = 4;
    localparam int CFG_W          = 2 * WORD_CNT_W;

    // field positions inside the command byte
    localparam int CMD_EN      = 0;
    localparam int CMD_CLR_RX  = 1;
    localparam int CMD_CLR_TX  = 2;
    localparam int CMD_TXX_LSB = 4;
    localparam int CMD_RXX_LSB = 6;

    // field positions inside the mode byte
    localparam int MODE_IDLE = 0;
    localparam int MODE_TXG  = 1;
    localparam int MODE_RXG  = 2;

    typedef enum logic [1:0] {
        SEL_WORDS = 2'd0,
        SEL_CMD   = 2'd1,
        SEL_MODE  = 2'd2,
        SEL_NONE  = 2'd3
    } cfg_sel_e;

    typedef struct packed {
        logic [WORD_CNT_W-1:0] tx_words;
        logic [WORD_CNT_W-1:0] rx_words;
        logic [EXTRA_W-1:0]    tx_extra;
        logic [EXTRA_W-1:0]    rx_extra;
        logic                  fifo_en;
        logic                  tx_gran;
        logic                  rx_gran;
        logic                  idle_sel;
        logic                  tx_ovf;
    } ctl_t;

endpackage

// File: rtl/uart_byte_fifo.sv
module uart_byte_fifo #(
    parameter  int DEPTH = 64,
    parameter  int DW    = 8,
    localparam int AW    = $clog2(DEPTH),
    localparam int LW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_en,
    input  logic          clear,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          pop,
    output logic [DW-1:0] dout,
    output logic [LW-1:0] level
);

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [LW-1:0] lvl;
    } ptr_t;

    ptr_t          st_q, st_d;
    logic [DW-1:0] mem [DEPTH];
    logic [LW-1:0] cap;
    logic          full, empty, do_push, do_pop;

    always_comb begin
        cap     = fifo_en ? LW'(DEPTH) : LW'(1);
        full    = (st_q.lvl >= cap);
        empty   = (st_q.lvl == '0);
        do_push = push && !full && !clear;
        do_pop  = pop && !empty && !clear;
        st_d    = st_q;
        if (clear) begin
            st_d = '0;
        end else begin
            if (do_push) st_d.wr = st_q.wr + AW'(1);
            if (do_pop)  st_d.rd = st_q.rd + AW'(1);
            st_d.lvl = st_q.lvl + LW'(do_push) - LW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[st_q.wr] <= din;
    end

    assign dout  = empty ? '0 : mem[st_q.rd];
    assign level = st_q.lvl;

    AST_FULL_PUSH_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        push && full && !pop && !clear |=> $stable(st_q.lvl) && $stable(st_q.wr)); // R9
    AST_EMPTY_POP_HARMLESS: assert property (@(posedge clk) disable iff (!rst_n)
        pop && empty && !push && !clear |=> $stable(st_q.lvl) && $stable(st_q.rd)); // R10
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (level == '0)); // R2
    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH)); // R11

endmodule

// File: rtl/uart_burst_decode.sv
module uart_burst_decode
    import uart_fifo_pkg::*;
#(
    parameter int LW = 7
) (
    input  logic [WORD_CNT_W-1:0] words,
    input  logic [EXTRA_W-1:0]    extra,
    input  logic                  gran,
    input  logic                  fifo_en,
    output logic [LW-1:0]         burst
);

    logic [LW-1:0] raw;

    always_comb begin
        raw = LW'(words) * LW'(BYTES_PER_WORD) + (gran ? LW'(extra) : '0);
        if (!fifo_en || raw == '0) burst = LW'(1);
        else                       burst = raw;
    end

endmodule

// File: rtl/uart_rx_timeout.sv
module uart_rx_timeout #(
    parameter  int CHARS = 4,
    localparam int CW    = $clog2(CHARS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic restart,
    input  logic tick,
    output logic fire
);

    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (!arm || restart)                    cnt_d = '0;
        else if (tick && cnt_q < CW'(CHARS))    cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign fire = arm && (cnt_q == CW'(CHARS));

    AST_TIMEOUT_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fire) |-> $past(tick)); // R8
    AST_RESTART_QUIETS: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !fire); // R8

endmodule

// File: rtl/uart_fifo_irq.sv
module uart_fifo_irq
    import uart_fifo_pkg::*;
#(
    parameter  int DEPTH    = 64,
    parameter  int DW       = 8,
    parameter  int TO_CHARS = 4,
    localparam int LW       = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [1:0]       cfg_sel,
    input  logic [CFG_W-1:0] cfg_data,
    input  logic             tx_irq_en,
    input  logic             rx_irq_en,
    input  logic             tx_push,
    input  logic [DW-1:0]    tx_data,
    input  logic             rx_pop,
    output logic [DW-1:0]    rx_data,
    input  logic             ser_tx_pop,
    output logic [DW-1:0]    ser_tx_data,
    input  logic             ser_rx_push,
    input  logic [DW-1:0]    ser_rx_data,
    input  logic             ser_busy,
    input  logic             char_tick,
    output logic             tx_ready_irq,
    output logic             rx_burst_irq,
    output logic             rx_timeout_irq,
    output logic             tx_idle,
    output logic [LW-1:0]    tx_level,
    output logic [LW-1:0]    rx_level,
    output logic             tx_overflow
);

    ctl_t          ctl_q, ctl_d;
    logic          wr_cmd, clr_tx, clr_rx, tx_drop;
    logic [LW-1:0] cap, tx_burst, rx_burst;
    logic          tx_room, rx_arm, rx_restart, to_fire;

    assign wr_cmd = cfg_wr && (cfg_sel_e'(cfg_sel) == SEL_CMD);
    assign clr_tx = wr_cmd && cfg_data[CMD_CLR_TX];
    assign clr_rx = wr_cmd && cfg_data[CMD_CLR_RX];
    assign cap    = ctl_q.fifo_en ? LW'(DEPTH) : LW'(1);
    assign tx_drop = tx_push && (tx_level >= cap) && !clr_tx;

    always_comb begin
        ctl_d = ctl_q;
        if (cfg_wr) begin
            case (cfg_sel_e'(cfg_sel))
                SEL_WORDS: begin
                    ctl_d.tx_words = cfg_data[WORD_CNT_W-1:0];
                    ctl_d.rx_words = cfg_data[CFG_W-1:WORD_CNT_W];
                end
                SEL_CMD: begin
                    ctl_d.fifo_en  = cfg_data[CMD_EN];
                    ctl_d.tx_extra = cfg_data[CMD_TXX_LSB +: EXTRA_W];
                    ctl_d.rx_extra = cfg_data[CMD_RXX_LSB +: EXTRA_W];
                end
                SEL_MODE: begin
                    ctl_d.idle_sel = cfg_data[MODE_IDLE];
                    ctl_d.tx_gran  = cfg_data[MODE_TXG];
                    ctl_d.rx_gran  = cfg_data[MODE_RXG];
                end
                default: ;
            endcase
        end
        if (clr_tx)       ctl_d.tx_ovf = 1'b0;
        else if (tx_drop) ctl_d.tx_ovf = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    uart_byte_fifo #(.DEPTH(DEPTH), .DW(DW)) u_tx_fifo (
        .clk(clk), .rst_n(rst_n), .fifo_en(ctl_q.fifo_en), .clear(clr_tx),
        .push(tx_push), .din(tx_data), .pop(ser_tx_pop),
        .dout(ser_tx_data), .level(tx_level)
    );

    uart_byte_fifo #(.DEPTH(DEPTH), .DW(DW)) u_rx_fifo (
        .clk(clk), .rst_n(rst_n), .fifo_en(ctl_q.fifo_en), .clear(clr_rx),
        .push(ser_rx_push), .din(ser_rx_data), .pop(rx_pop),
        .dout(rx_data), .level(rx_level)
    );

    uart_burst_decode #(.LW(LW)) u_tx_burst (
        .words(ctl_q.tx_words), .extra(ctl_q.tx_extra), .gran(ctl_q.tx_gran),
        .fifo_en(ctl_q.fifo_en), .burst(tx_burst)
    );

    uart_burst_decode #(.LW(LW)) u_rx_burst (
        .words(ctl_q.rx_words), .extra(ctl_q.rx_extra), .gran(ctl_q.rx_gran),
        .fifo_en(ctl_q.fifo_en), .burst(rx_burst)
    );

    assign rx_arm     = (rx_level != '0) && (rx_level < rx_burst);
    assign rx_restart = ser_rx_push || rx_pop;

    uart_rx_timeout #(.CHARS(TO_CHARS)) u_timeout (
        .clk(clk), .rst_n(rst_n), .arm(rx_arm), .restart(rx_restart),
        .tick(char_tick), .fire(to_fire)
    );

    assign tx_room        = (tx_level + tx_burst) <= cap;
    assign tx_idle        = (tx_level == '0) && !ser_busy;
    assign tx_ready_irq   = tx_irq_en && (ctl_q.idle_sel ? tx_idle : tx_room);
    assign rx_burst_irq   = rx_irq_en && (rx_level >= rx_burst);
    assign rx_timeout_irq = rx_irq_en && to_fire;
    assign tx_overflow    = ctl_q.tx_ovf;

    AST_TX_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_q.idle_sel && tx_push && !ser_tx_pop && !cfg_wr
        && (tx_level + tx_burst == cap) |=> !tx_ready_irq); // R4
    AST_IDLE_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.idle_sel && tx_push && !cfg_wr |=> !tx_ready_irq); // R5
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        tx_overflow && !clr_tx |=> tx_overflow); // R9
    AST_RX_BURST_REACHED: assert property (@(posedge clk) disable iff (!rst_n)
        ser_rx_push && !rx_pop && !cfg_wr && (rx_level + LW'(1) == rx_burst)
        |=> (rx_burst_irq || !rx_irq_en)); // R7

endmodule

// File: tb/uart_fifo_irq_test.sv
`timescale 1ns/1ps
module uart_fifo_irq_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cfg_wr;
    logic [1:0] cfg_sel;
    logic [7:0] cfg_data;
    logic       tx_irq_en, rx_irq_en;
    logic       tx_push, rx_pop, ser_tx_pop, ser_rx_push, ser_busy, char_tick;
    logic [7:0] tx_data, ser_rx_data, rx_data, ser_tx_data;
    logic       tx_ready_irq, rx_burst_irq, rx_timeout_irq, tx_idle, tx_overflow;
    logic [6:0] tx_level, rx_level;

    int n_chk  = 0;
    int n_fail = 0;

    uart_fifo_irq uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
        .tx_irq_en(tx_irq_en), .rx_irq_en(rx_irq_en), .tx_push(tx_push), .tx_data(tx_data),
        .rx_pop(rx_pop), .rx_data(rx_data), .ser_tx_pop(ser_tx_pop), .ser_tx_data(ser_tx_data),
        .ser_rx_push(ser_rx_push), .ser_rx_data(ser_rx_data), .ser_busy(ser_busy),
        .char_tick(char_tick), .tx_ready_irq(tx_ready_irq), .rx_burst_irq(rx_burst_irq),
        .rx_timeout_irq(rx_timeout_irq), .tx_idle(tx_idle), .tx_level(tx_level),
        .rx_level(rx_level), .tx_overflow(tx_overflow)
    );

    always #10 clk = ~clk;

    typedef struct packed {
        logic [3:0] tw;
        logic [3:0] rw;
        logic [1:0] txx;
        logic [1:0] rxx;
        logic       tg;
        logic       rg;
        logic [6:0] exp_tx;
        logic [6:0] exp_rx;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{4'd0,  4'd8,  2'd1, 2'd0, 1'b1, 1'b1, 7'd1,  7'd32},
        '{4'd2,  4'd1,  2'd3, 2'd2, 1'b0, 1'b1, 7'd8,  7'd6},
        '{4'd15, 4'd15, 2'd3, 2'd3, 1'b1, 1'b1, 7'd63, 7'd63},
        '{4'd0,  4'd0,  2'd0, 2'd0, 1'b1, 1'b1, 7'd1,  7'd1},
        '{4'd3,  4'd0,  2'd2, 2'd3, 1'b1, 1'b0, 7'd14, 7'd1},
        '{4'd0,  4'd2,  2'd2, 2'd1, 1'b1, 1'b1, 7'd2,  7'd9}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic cfg(input logic [1:0] s, input logic [7:0] d);
        cfg_wr = 1'b1; cfg_sel = s; cfg_data = d;
        step();
        cfg_wr = 1'b0;
    endtask

    task automatic host_push(input logic [7:0] d);
        tx_push = 1'b1; tx_data = d;
        step();
        tx_push = 1'b0;
    endtask

    task automatic host_pop();
        rx_pop = 1'b1;
        step();
        rx_pop = 1'b0;
    endtask

    task automatic ser_push(input logic [7:0] d);
        ser_rx_push = 1'b1; ser_rx_data = d;
        step();
        ser_rx_push = 1'b0;
    endtask

    task automatic ser_pop();
        ser_tx_pop = 1'b1;
        step();
        ser_tx_pop = 1'b0;
    endtask

    task automatic tick();
        char_tick = 1'b1;
        step();
        char_tick = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cfg_wr = 1'b0; cfg_sel = 2'd0; cfg_data = 8'h00;
        tx_irq_en = 1'b1; rx_irq_en = 1'b1;
        tx_push = 1'b0; rx_pop = 1'b0; ser_tx_pop = 1'b0; ser_rx_push = 1'b0;
        ser_busy = 1'b0; char_tick = 1'b0; tx_data = 8'h00; ser_rx_data = 8'h00;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 tx_level", tx_level, 0);
        chk("R1 rx_level", rx_level, 0);
        chk("R1 tx_overflow", tx_overflow, 0);
        chk("R1 rx_burst_irq", rx_burst_irq, 0);
        chk("R1 rx_timeout_irq", rx_timeout_irq, 0);
        chk("R1 tx_ready_irq", tx_ready_irq, 1);

        // R6 FIFOs disabled after reset: one-byte capacity, one-byte bursts
        host_push(8'hA5);
        chk("R6 tx_level", tx_level, 1);
        chk("R6 tx_ready low", tx_ready_irq, 0);
        host_push(8'h5A);
        chk("R9 drop keeps level", tx_level, 1);
        chk("R9 overflow set", tx_overflow, 1);
        chk("R6 head byte", ser_tx_data, 8'hA5);
        ser_pop();
        chk("R6 tx_ready back", tx_ready_irq, 1);
        ser_push(8'h3C);
        chk("R6 rx burst of one", rx_burst_irq, 1);
        ser_push(8'h4D);
        chk("R6 rx capacity one", rx_level, 1);
        chk("R11 rx head", rx_data, 8'h3C);

        // R2 clear and enable
        cfg(2'd1, 8'h07);
        chk("R2 rx cleared", rx_level, 0);
        chk("R2 tx cleared", tx_level, 0);
        chk("R9 overflow cleared", tx_overflow, 0);

        // R11 ordering, R10 empty pop
        ser_push(8'h11); ser_push(8'h22); ser_push(8'h33);
        chk("R11 rx_level", rx_level, 3);
        chk("R11 order 1", rx_data, 8'h11); host_pop();
        chk("R11 order 2", rx_data, 8'h22); host_pop();
        chk("R11 order 3", rx_data, 8'h33); host_pop();
        chk("R10 empty data", rx_data, 8'h00);
        host_pop();
        chk("R10 level stays", rx_level, 0);
        ser_push(8'h44);
        chk("R10 state intact", rx_data, 8'h44);
        host_pop();

        // R5 idle selection
        cfg(2'd2, 8'h01);
        ser_busy = 1'b1; #1;
        chk("R5 busy blocks", tx_ready_irq, 0);
        chk("R5 tx_idle busy", tx_idle, 0);
        ser_busy = 1'b0; #1;
        chk("R5 idle raises", tx_ready_irq, 1);
        host_push(8'h77);
        chk("R5 data blocks", tx_ready_irq, 0);
        ser_pop();
        chk("R5 drained", tx_ready_irq, 1);
        cfg(2'd2, 8'h00);

        // R8 receive timeout, read burst 4
        cfg(2'd0, 8'h10);
        ser_push(8'h01); ser_push(8'h02);
        tick(); tick(); tick();
        chk("R8 three ticks", rx_timeout_irq, 0);
        ser_push(8'h03);
        tick(); tick(); tick();
        chk("R8 push restarts", rx_timeout_irq, 0);
        tick();
        chk("R8 fires", rx_timeout_irq, 1);
        chk("R7 below burst", rx_burst_irq, 0);
        host_pop();
        chk("R8 pop restarts", rx_timeout_irq, 0);
        cfg(2'd1, 8'h07);

        // R4 threshold, write burst 8
        cfg(2'd0, 8'h02);
        for (int i = 0; i < 56; i++) host_push(8'(i));
        chk("R4 at threshold", tx_ready_irq, 1);
        host_push(8'hF0);
        chk("R4 level", tx_level, 57);
        chk("R4 drops", tx_ready_irq, 0);
        ser_pop();
        chk("R4 reasserts", tx_ready_irq, 1);
        host_push(8'hF1);
        chk("R4 drops again", tx_ready_irq, 0);
        cfg(2'd0, 8'h01);
        chk("R12 smaller burst", tx_ready_irq, 1);

        // R9 full FIFO
        for (int i = 0; i < 7; i++) host_push(8'hE0);
        chk("R9 full level", tx_level, 64);
        host_push(8'hEE);
        chk("R9 full drop", tx_level, 64);
        chk("R9 full overflow", tx_overflow, 1);
        cfg(2'd1, 8'h07);
        chk("R2 tx cleared", tx_level, 0);

        // R3 / R7 burst decode table
        for (int v = 0; v < NV; v++) begin
            int n;
            int m;
            cfg(2'd2, {5'd0, VECS[v].rg, VECS[v].tg, 1'b0});
            cfg(2'd0, {VECS[v].rw, VECS[v].tw});
            cfg(2'd1, {VECS[v].rxx, VECS[v].txx, 4'b0111});
            n = 0;
            while (tx_ready_irq && n < 70) begin
                host_push(8'(n));
                n++;
            end
            chk("R3 write burst pushes", n, 65 - int'(VECS[v].exp_tx));
            m = 0;
            while (!rx_burst_irq && m < 70) begin
                ser_push(8'(m));
                m++;
            end
            chk("R7 read burst pushes", m, int'(VECS[v].exp_rx));
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule